// File: doc/BRIEF.md
# Initialization Record Fetch Sequencer

This block is a bus master that pulls a fixed-length configuration record out of system memory and hands it, one DWord at a time, to the registers that consume it. A single start pulse supplies a base address, a layout select (wide 32-bit structures or narrow 16-bit structures) and a burst select. The sequencer then asks for the bus, performs two DWord reads, gives the bus back, and repeats until the whole record has been read.

Every bus tenure holds exactly two read data phases. The number of tenures follows from the record length. The wide record is seven DWords, so it takes four tenures. The eighth read in that case lands past the end of the record, and its data is dropped inside the block. The narrow record is six DWords, so it takes three tenures. With burst clear, each read gets its own address phase. With burst set, the two reads of a tenure share one address phase.

Received DWords leave the block on a valid strobe together with their index. A one-clock done pulse closes a successful fetch. A one-clock error pulse closes a fetch in which no target claimed a read.

Top module: `irec_fetch`

## Requirements
- R1: While reset is applied and in the first clock after it, req_o, frame_o, irdy_o, dw_valid_o, done_o and err_o are all low.
- R2: When start_i is high on a clock while the block is idle, a fetch begins and req_o is high on the next clock. A start_i pulse during a running fetch changes neither the addresses read nor the record delivered, and does not begin a second fetch once the first one ends.
- R3: The first address phase of a tenure follows a clock on which gnt_i was high and bus_busy_i was low. While bus_busy_i stays high, req_o stays high and frame_o stays low.
- R4: During an address phase (frame_o high, irdy_o low), cbe_o carries the memory-read code 4'b0110 and ad_o carries the read address. During a data phase (irdy_o high), cbe_o is 4'b0000. A data phase completes on a clock where irdy_o, trdy_i and devsel_i are all high.
- R5: Read number k of a fetch, counted from 0 across all tenures, uses address base + 4*k.
- R6: After the second data phase of a tenure completes, req_o, frame_o and irdy_o are all low on the next clock, so the bus is released between tenures.
- R7: req_o is high during the first data phase of a tenure and low during its second, final data phase.
- R8: With burst_en_i low, every read has its own address phase, and frame_o is low in every data phase.
- R9: With burst_en_i high, each tenure has one address phase. frame_o is high during the tenure's first data phase and low during its second.
- R10: With wide_layout_i high, the fetch performs 8 reads in 4 tenures. It presents DWords 0 to 6 with dw_index_o equal to k, and dw_data_o equal to the data read at base + 4*k, on dw_valid_o in the clock after each read completes. The eighth read produces no dw_valid_o.
- R11: With wide_layout_i low, the fetch performs 6 reads in 3 tenures and presents DWords 0 to 5 in the same way.
- R12: done_o is high for exactly one clock per successful fetch. It follows the last dw_valid_o by one clock in the narrow layout, and comes after the last dw_valid_o in the wide layout.
- R13: If devsel_i is not high in any of the first four data-phase clocks after an address phase, the fetch ends. err_o pulses for one clock, done_o does not pulse, and req_o, frame_o and irdy_o return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a fetch (taken only when idle) |
| base_addr_i | input | AW | DWord-aligned record base address |
| wide_layout_i | input | 1 | 1: 7-DWord record, 0: 6-DWord record |
| burst_en_i | input | 1 | 1: one address phase per tenure |
| gnt_i | input | 1 | Bus grant |
| bus_busy_i | input | 1 | Another master still owns the bus |
| devsel_i | input | 1 | Target claims the access |
| trdy_i | input | 1 | Target ready |
| ad_i | input | DW | Read data from the target |
| req_o | output | 1 | Bus request |
| frame_o | output | 1 | Transaction framing |
| irdy_o | output | 1 | Master ready (data phase) |
| ad_o | output | AW | Address during the address phase, zero otherwise |
| cbe_o | output | 4 | Command or byte enables |
| dw_valid_o | output | 1 | Record DWord strobe |
| dw_index_o | output | IDX_W | Index of the presented DWord |
| dw_data_o | output | DW | Presented DWord |
| done_o | output | 1 | Fetch completed |
| err_o | output | 1 | Fetch ended because no target claimed a read |

## Verification
The properties assume a well-behaved target. It raises trdy_i only together with devsel_i and only while irdy_o is high, it keeps gnt_i high for the whole tenure once it has granted, and start_i is a short pulse. The bench's target model drives devsel_i and trdy_i on the same clock, from the clock after irdy_o rises, optionally after a few wait clocks. It grants only while req_o is high, and it always uses DWord-aligned base addresses. The timeout case is produced by withholding devsel_i entirely, never by a late or partial claim.

// File: rtl/irf_pkg.sv
package irf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_DATA,
      ST_REL,
      ST_FIN
   } irf_state_e;

   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] BE_ALL_ON  = 4'b0000;

   // number of reads needed to cover a record, rounded up to whole tenures
   function automatic int unsigned irf_reads(int unsigned dwords, int unsigned per);
      return ((dwords + per - 1) / per) * per;
   endfunction

   function automatic int unsigned irf_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/irf_dsel_watch.sv
module irf_dsel_watch #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic active_i,
   input  logic devsel_i,
   output logic claimed_o,
   output logic timeout_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          seen_q;

   assign claimed_o = seen_q || devsel_i;
   assign timeout_o = active_i && !claimed_o && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (arm_i) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (active_i) begin
         if (devsel_i) seen_q <= 1'b1;
         if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/irf_seq.sv
module irf_seq
   import irf_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned PER_TEN   = 2,
   parameter int unsigned WIDE_DW   = 7,
   parameter int unsigned NARROW_DW = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [AW-1:0]    base_i,
   input  logic             wide_i,
   input  logic             burst_i,
   input  logic             gnt_i,
   input  logic             bus_busy_i,
   input  logic             xfer_i,
   input  logic             abort_i,
   output irf_state_e       state_o,
   output logic [AW-1:0]    addr_o,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic             keep_o,
   output logic             last_ph_o,
   output logic             burst_o
);
   localparam int unsigned PH_W = $clog2(PER_TEN);
   localparam logic [IDX_W-1:0] WIDE_LAST   = IDX_W'(irf_reads(WIDE_DW, PER_TEN) - 1);
   localparam logic [IDX_W-1:0] NARROW_LAST = IDX_W'(irf_reads(NARROW_DW, PER_TEN) - 1);
   localparam logic [IDX_W-1:0] WIDE_LEN    = IDX_W'(WIDE_DW);
   localparam logic [IDX_W-1:0] NARROW_LEN  = IDX_W'(NARROW_DW);
   localparam logic [PH_W-1:0]  PH_LAST     = PH_W'(PER_TEN - 1);

   irf_state_e       st_q, st_d;
   logic [AW-1:0]    addr_q;
   logic [IDX_W-1:0] idx_q;
   logic [PH_W-1:0]  ph_q;
   logic             wide_q, burst_q;
   logic             last_ph, last_rd, take;

   assign last_ph = (ph_q == PH_LAST);
   assign last_rd = (idx_q == (wide_q ? WIDE_LAST : NARROW_LAST));
   assign take    = (st_q == ST_DATA) && xfer_i && !abort_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start_i) st_d = ST_REQ;
         ST_REQ:  if (gnt_i && !bus_busy_i) st_d = ST_ADDR;
         ST_ADDR: st_d = ST_DATA;
         ST_DATA: begin
            if (abort_i)       st_d = ST_IDLE;
            else if (xfer_i) begin
               if (!last_ph)     st_d = burst_q ? ST_DATA : ST_ADDR;
               else if (last_rd) st_d = ST_FIN;
               else              st_d = ST_REL;
            end
         end
         ST_REL:  st_d = ST_REQ;
         ST_FIN:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         idx_q   <= '0;
         ph_q    <= '0;
         wide_q  <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start_i) begin
            addr_q  <= base_i;
            wide_q  <= wide_i;
            burst_q <= burst_i;
            idx_q   <= '0;
            ph_q    <= '0;
         end else if (take) begin
            addr_q <= addr_q + AW'(4);
            idx_q  <= idx_q + 1'b1;
            ph_q   <= last_ph ? '0 : ph_q + 1'b1;
         end
      end
   end

   assign state_o   = st_q;
   assign addr_o    = addr_q;
   assign rd_idx_o  = idx_q;
   assign keep_o    = idx_q < (wide_q ? WIDE_LEN : NARROW_LEN);
   assign last_ph_o = last_ph;
   assign burst_o   = burst_q;
endmodule

// File: rtl/irf_out.sv
module irf_out #(
   parameter int unsigned DW    = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_i,
   input  logic             keep_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [DW-1:0]    data_i,
   input  logic             fin_i,
   input  logic             abort_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [DW-1:0]    data_o,
   output logic             done_o,
   output logic             err_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         idx_o   <= '0;
         data_o  <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= xfer_i && keep_i;
         if (xfer_i && keep_i) begin
            idx_o  <= idx_i;
            data_o <= data_i;
         end
         done_o <= fin_i;
         err_o  <= abort_i;
      end
   end
endmodule

// File: rtl/irec_fetch.sv
module irec_fetch
   import irf_pkg::*;
#(
   parameter int unsigned AW           = 32,
   parameter int unsigned DW           = 32,
   parameter int unsigned IDX_W        = 4,
   parameter int unsigned PER_TENURE   = 2,
   parameter int unsigned WIDE_DW      = 7,
   parameter int unsigned NARROW_DW    = 6,
   parameter int unsigned DEVSEL_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [AW-1:0]    base_addr_i,
   input  logic             wide_layout_i,
   input  logic             burst_en_i,
   input  logic             gnt_i,
   input  logic             bus_busy_i,
   input  logic             devsel_i,
   input  logic             trdy_i,
   input  logic [DW-1:0]    ad_i,
   output logic             req_o,
   output logic             frame_o,
   output logic             irdy_o,
   output logic [AW-1:0]    ad_o,
   output logic [3:0]       cbe_o,
   output logic             dw_valid_o,
   output logic [IDX_W-1:0] dw_index_o,
   output logic [DW-1:0]    dw_data_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int unsigned MAX_RD =
      irf_max(irf_reads(WIDE_DW, PER_TENURE), irf_reads(NARROW_DW, PER_TENURE));

   // elaboration-time parameter checks
   if (PER_TENURE < 2) begin : g_bad_per
      $error("PER_TENURE must be at least 2");
   end
   if ((1 << IDX_W) <= MAX_RD) begin : g_bad_idx
      $error("IDX_W too narrow for the read count");
   end
   if (DEVSEL_LIMIT < 1) begin : g_bad_lim
      $error("DEVSEL_LIMIT must be at least 1");
   end
   if (AW < 3 || WIDE_DW < 1 || NARROW_DW < 1) begin : g_bad_geom
      $error("invalid address width or record length");
   end

   irf_state_e       st;
   logic [AW-1:0]    addr;
   logic [IDX_W-1:0] rd_idx;
   logic             keep, last_ph, burst_q;
   logic             claimed, timeout, xfer;
   logic             in_addr, in_data;

   assign in_addr = (st == ST_ADDR);
   assign in_data = (st == ST_DATA);
   assign xfer    = in_data && trdy_i && claimed;

   irf_seq #(
      .AW(AW), .IDX_W(IDX_W), .PER_TEN(PER_TENURE),
      .WIDE_DW(WIDE_DW), .NARROW_DW(NARROW_DW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_addr_i),
      .wide_i(wide_layout_i), .burst_i(burst_en_i), .gnt_i(gnt_i),
      .bus_busy_i(bus_busy_i), .xfer_i(xfer), .abort_i(timeout),
      .state_o(st), .addr_o(addr), .rd_idx_o(rd_idx), .keep_o(keep),
      .last_ph_o(last_ph), .burst_o(burst_q)
   );

   irf_dsel_watch #(.LIMIT(DEVSEL_LIMIT)) u_watch (
      .clk(clk), .rst_n(rst_n), .arm_i(in_addr), .active_i(in_data),
      .devsel_i(devsel_i), .claimed_o(claimed), .timeout_o(timeout)
   );

   irf_out #(.DW(DW), .IDX_W(IDX_W)) u_out (
      .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .keep_i(keep), .idx_i(rd_idx),
      .data_i(ad_i), .fin_i(st == ST_FIN), .abort_i(timeout),
      .valid_o(dw_valid_o), .idx_o(dw_index_o), .data_o(dw_data_o),
      .done_o(done_o), .err_o(err_o)
   );

   assign req_o   = (st == ST_REQ) || in_addr || (in_data && !last_ph);
   assign frame_o = in_addr || (in_data && burst_q && !last_ph);
   assign irdy_o  = in_data;
   assign ad_o    = in_addr ? addr : '0;
   assign cbe_o   = in_addr ? CMD_MEM_RD : BE_ALL_ON;
endmodule

// File: rtl/irec_fetch_chk.sv
module irec_fetch_chk #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned WIDE_DW = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_o,
   input logic             frame_o,
   input logic             irdy_o,
   input logic [3:0]       cbe_o,
   input logic             trdy_i,
   input logic             devsel_i,
   input logic             gnt_i,
   input logic             bus_busy_i,
   input logic             dw_valid_o,
   input logic [IDX_W-1:0] dw_index_o,
   input logic             done_o,
   input logic             err_o
);
   // R4: command code during address phase
   a_r4_addr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o && !irdy_o |-> cbe_o == 4'b0110);

   // R4: all byte lanes enabled during data phase
   a_r4_data_be: assert property (@(posedge clk) disable iff (!rst_n)
      irdy_o |-> cbe_o == 4'b0000);

   // R3: a tenure's first address phase needs grant and a free bus
   a_r3_granted: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o && !irdy_o && !$past(irdy_o) |-> $past(gnt_i) && !$past(bus_busy_i));

   // R6, R7: final data phase of a tenure completes, then the bus is released
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      irdy_o && !req_o && trdy_i && devsel_i |=> !req_o && !frame_o && !irdy_o);

   // R10: presented index never reaches past the record
   a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      dw_valid_o |-> int'(dw_index_o) < WIDE_DW);

   // R12: done is a single-clock pulse
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R13: error is a single-clock pulse, never with done
   a_r13_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o && !done_o);

   a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
endmodule

bind irec_fetch irec_fetch_chk #(.IDX_W(IDX_W), .WIDE_DW(WIDE_DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_o(req_o), .frame_o(frame_o), .irdy_o(irdy_o),
   .cbe_o(cbe_o), .trdy_i(trdy_i), .devsel_i(devsel_i), .gnt_i(gnt_i),
   .bus_busy_i(bus_busy_i), .dw_valid_o(dw_valid_o), .dw_index_o(dw_index_o),
   .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_irec_fetch.sv
module tb_irec_fetch;
   localparam int unsigned AW = 32, DW = 32, IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [AW-1:0]    base_addr_i = '0;
   logic             wide_layout_i = 1'b0, burst_en_i = 1'b0;
   logic             gnt_i = 1'b0, bus_busy_i = 1'b0, devsel_i = 1'b0, trdy_i = 1'b0;
   logic [DW-1:0]    ad_i = '0;
   logic             req_o, frame_o, irdy_o, dw_valid_o, done_o, err_o;
   logic [AW-1:0]    ad_o;
   logic [3:0]       cbe_o;
   logic [IDX_W-1:0] dw_index_o;
   logic [DW-1:0]    dw_data_o;

   irec_fetch dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .wide_layout_i(wide_layout_i), .burst_en_i(burst_en_i), .gnt_i(gnt_i),
      .bus_busy_i(bus_busy_i), .devsel_i(devsel_i), .trdy_i(trdy_i), .ad_i(ad_i),
      .req_o(req_o), .frame_o(frame_o), .irdy_o(irdy_o), .ad_o(ad_o), .cbe_o(cbe_o),
      .dw_valid_o(dw_valid_o), .dw_index_o(dw_index_o), .dw_data_o(dw_data_o),
      .done_o(done_o), .err_o(err_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   int tests = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc++;

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h0101};
   endfunction

   // configuration of the target / arbiter model
   logic [31:0] cfg_base = '0;
   bit cfg_burst = 0, cfg_nodev = 0;
   int cfg_waits = 0, cfg_gdelay = 0;

   // target model state
   int rd_seen = 0, addr_ph = 0, wcnt = 0, gcnt = 0;
   bit pend = 0;
   logic [31:0] cur_addr = '0;

   // scoreboard
   int q_idx[$];
   logic [31:0] q_dat[$];
   int done_cnt = 0, err_cnt = 0, done_cyc = 0, last_valid_cyc = 0;

   // target and arbiter: sample outputs, drive inputs for the next edge
   always @(negedge clk) begin
      if (req_o) begin
         if (gcnt >= cfg_gdelay) gnt_i = 1'b1; else gcnt++;
      end else begin
         gnt_i = 1'b0;
         gcnt  = 0;
      end
      trdy_i   = 1'b0;
      devsel_i = 1'b0;
      if (pend) begin
         pend = 0;
         rd_seen++;
         wcnt = 0;
         cur_addr = cur_addr + 32'd4;
         if (rd_seen % 2 == 0)
            chk(!req_o && !frame_o && !irdy_o, "R6 bus released after tenure",
                {29'b0, req_o, frame_o, irdy_o}, 32'h0);
      end
      if (frame_o && !irdy_o) begin
         addr_ph++;
         cur_addr = ad_o;
         chk(ad_o == cfg_base + 32'(4 * rd_seen), "R5 read address", ad_o,
             cfg_base + 32'(4 * rd_seen));
         chk(cbe_o == 4'b0110, "R4 address-phase command", {28'b0, cbe_o}, 32'h6);
      end else if (irdy_o) begin
         chk(cbe_o == 4'b0000, "R4 data-phase byte enables", {28'b0, cbe_o}, 32'h0);
         chk(req_o == (rd_seen % 2 == 0), "R7 request in data phase",
             {31'b0, req_o}, {31'b0, rd_seen % 2 == 0});
         chk(frame_o == (cfg_burst && rd_seen % 2 == 0),
             cfg_burst ? "R9 frame in burst data phase" : "R8 frame in single data phase",
             {31'b0, frame_o}, {31'b0, cfg_burst && rd_seen % 2 == 0});
         if (!cfg_nodev) begin
            if (wcnt >= cfg_waits) begin
               trdy_i   = 1'b1;
               devsel_i = 1'b1;
               ad_i     = mem_word(cur_addr);
               pend     = 1;
            end else begin
               wcnt++;
            end
         end
      end
   end

   // monitor: pop expected DWords as the design presents them
   always @(negedge clk) begin
      if (rst_n && dw_valid_o) begin
         last_valid_cyc = cyc;
         if (q_idx.size() == 0) begin
            chk(0, "R10 unexpected DWord (discard)", {28'b0, dw_index_o}, 32'hFFFF_FFFF);
         end else begin
            int ei;
            logic [31:0] ed;
            ei = q_idx.pop_front();
            ed = q_dat.pop_front();
            chk(int'(dw_index_o) == ei, "R10/R11 DWord index", {28'b0, dw_index_o}, 32'(ei));
            chk(dw_data_o == ed, "R10/R11 DWord data", dw_data_o, ed);
         end
      end
      if (rst_n && done_o) begin done_cnt++; done_cyc = cyc; end
      if (rst_n && err_o) err_cnt++;
   end

   task automatic run_fetch(logic [31:0] base, bit wide, bit burst, int waits,
                            int gdelay, bit inject, bit nodev, bit hold_busy);
      int len, reads, n;
      len   = wide ? 7 : 6;
      reads = wide ? 8 : 6;
      cfg_base = base; cfg_burst = burst; cfg_nodev = nodev;
      cfg_waits = waits; cfg_gdelay = gdelay;
      rd_seen = 0; addr_ph = 0; wcnt = 0; pend = 0;
      done_cnt = 0; err_cnt = 0; done_cyc = 0; last_valid_cyc = 0;
      q_idx.delete(); q_dat.delete();
      if (!nodev)
         for (int k = 0; k < len; k++) begin
            q_idx.push_back(k);
            q_dat.push_back(mem_word(base + 32'(4 * k)));
         end
      @(negedge clk);
      bus_busy_i    = hold_busy;
      base_addr_i   = base;
      wide_layout_i = wide;
      burst_en_i    = burst;
      start_i       = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(req_o == 1'b1, "R2 request after start", {31'b0, req_o}, 32'h1);
      if (hold_busy) begin
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(req_o && !frame_o, "R3 wait while bus busy",
                {30'b0, req_o, frame_o}, 32'h2);
         end
         bus_busy_i = 1'b0;
      end
      if (inject) begin
         repeat (5) @(negedge clk);
         base_addr_i   = 32'h00F0_0000;
         wide_layout_i = ~wide;
         burst_en_i    = ~burst;
         start_i       = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      n = 0;
      while (done_cnt == 0 && err_cnt == 0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (6) @(negedge clk);
      chk(!req_o && !frame_o && !irdy_o, inject ? "R2 no second fetch" : "R2 idle after fetch",
          {29'b0, req_o, frame_o, irdy_o}, 32'h0);
      if (nodev) begin
         chk(err_cnt == 1, "R13 error pulse", 32'(err_cnt), 32'd1);
         chk(done_cnt == 0, "R13 no done on error", 32'(done_cnt), 32'd0);
         chk(rd_seen == 0, "R13 no reads completed", 32'(rd_seen), 32'd0);
      end else begin
         chk(err_cnt == 0, "R13 no error with claiming target", 32'(err_cnt), 32'd0);
         chk(done_cnt == 1, "R12 one done pulse", 32'(done_cnt), 32'd1);
         chk(q_idx.size() == 0, wide ? "R10 all DWords delivered" : "R11 all DWords delivered",
             32'(q_idx.size()), 32'd0);
         chk(rd_seen == reads, wide ? "R10 read count" : "R11 read count",
             32'(rd_seen), 32'(reads));
         chk(addr_ph == (burst ? reads / 2 : reads),
             burst ? "R9 address phases" : "R8 address phases",
             32'(addr_ph), 32'(burst ? reads / 2 : reads));
         if (wide)
            chk(done_cyc > last_valid_cyc, "R12 done after last DWord",
                32'(done_cyc), 32'(last_valid_cyc + 1));
         else
            chk(done_cyc == last_valid_cyc + 1, "R12 done one clock after last DWord",
                32'(done_cyc), 32'(last_valid_cyc + 1));
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!req_o && !frame_o && !irdy_o && !dw_valid_o && !done_o && !err_o,
          "R1 reset state", {26'b0, req_o, frame_o, irdy_o, dw_valid_o, done_o, err_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req_o && !frame_o && !irdy_o && !dw_valid_o && !done_o && !err_o,
          "R1 after reset", {26'b0, req_o, frame_o, irdy_o, dw_valid_o, done_o, err_o}, 32'h0);

      run_fetch(32'h0000_1000, 0, 0, 0, 0, 0, 0, 0);   // narrow, single reads
      run_fetch(32'h0004_2A40, 1, 0, 2, 1, 0, 0, 0);   // wide, single reads, waits
      run_fetch(32'h8000_0100, 1, 1, 0, 0, 1, 0, 0);   // wide burst, start injected
      run_fetch(32'h0123_4560, 0, 1, 1, 3, 0, 0, 0);   // narrow burst, slow grant
      run_fetch(32'h00A0_0000, 1, 1, 0, 0, 0, 0, 1);   // bus busy at start
      run_fetch(32'h0000_2000, 1, 0, 0, 0, 0, 1, 0);   // no target: timeout
      run_fetch(32'h0000_3000, 0, 0, 3, 0, 0, 0, 0);   // recovery after error

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule